// File: doc/BRIEF.md
# Bus-error replay controller for address requests

This block sits between the stage that forms address requests (read or write, one word each) and an in-order transport layer that carries them out one at a time. Every request that goes out is also written into a circular record, and it stays there until the transport layer reports that its transfer has finished. The oldest entry is therefore always the transfer now on the bus. A completion that reports an error thus always refers to that oldest entry.

On a clean completion the oldest entry is dropped and a good response goes to the requester. On an error the controller reports the fault (unless reporting is switched off), stops accepting and sending requests, and waits for a two-bit command: continue (drop the faulty entry), abort (drop every entry) or replay (send recorded entries again without removing them). Replay covers only the oldest entry when the serialized-mode pin is high, and every recorded entry in original order when it is low.

The request path is valid/ready at both ends. A request passes straight through, without a register, when the record has room. The input sees `in_ready` only when the output is ready, so one handshake at the input is always one handshake at the output. While the controller is replaying or waiting, the input is held off. Completion, command, mode and response pins are plain single-cycle signals.

Top module: `ax_replay_ctl`

## Requirements
- R1: After reset the record is empty: `out_valid`, `cmd_ready` and `rsp_valid` are 0, and `in_ready` equals `out_ready`.
- R2: In normal operation with room in the record, `out_valid` equals `in_valid`, `out_ax` equals `in_ax` and `in_ready` equals `out_ready`. Every input handshake adds one entry at the tail of the record.
- R3: When the record holds DEPTH entries, `in_ready` and `out_valid` are 0 in normal operation.
- R4: A completion with `done_err`=0 while the record is not empty and no command is awaited retires the oldest entry. In the next cycle it gives `rsp_valid`=1, `rsp_err`=0 and `rsp_cause`=0.
- R5: A completion with `done_err`=1 in the same conditions makes `cmd_ready` 1 from the next cycle until a command is taken. With `report_errors`=1 it also gives `rsp_valid`=1, `rsp_err`=1 and `rsp_cause`=`done_cause` in the next cycle. While `cmd_ready` is 1, `in_ready` and `out_valid` are 0 and completions are ignored.
- R6: With `report_errors`=0, an error completion gives no response pulse but still waits for a command.
- R7: Command `cmd_sel`=00 (continue) and the reserved code 11 drop the oldest entry and resume normal operation in the next cycle.
- R8: Command 01 (abort) drops every entry. The full DEPTH is then free again, and no later completion is answered until new entries are recorded.
- R9: Command 10 (replay) with `serial_mode`=1 presents the oldest entry alone on `out_ax` with `out_valid`=1 until accepted, then resumes normal operation.
- R10: Command 10 with `serial_mode`=0 presents every recorded entry from oldest to newest, one per output handshake, holding each entry until it is accepted. It then resumes normal operation. Clean completions during replay retire entries at the head.
- R11: Replay leaves entries recorded. An error during replay (after the oldest entry was re-sent) waits for a command again, and a second replay re-sends the same entries.
- R12: A completion while the record is empty is ignored and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| serial_mode | input | 1 | 1: replay the oldest entry only; 0: replay all entries |
| report_errors | input | 1 | 1: error completions give a response pulse |
| in_valid | input | 1 | Request offered by the upstream stage |
| in_ready | output | 1 | Request taken this cycle |
| in_ax | input | AX_W | Request word |
| out_valid | output | 1 | Request offered to the transport layer |
| out_ready | input | 1 | Transport layer takes the request |
| out_ax | output | AX_W | Request word to the transport layer |
| done_valid | input | 1 | Oldest in-flight transfer finished this cycle |
| done_err | input | 1 | That transfer ended in error |
| done_cause | input | CAUSE_W | Error cause code |
| cmd_valid | input | 1 | Command strobe |
| cmd_sel | input | 2 | 00 continue, 01 abort, 10 replay, 11 continue |
| cmd_ready | output | 1 | An error is waiting for a command |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | 0 OK, 1 error |
| rsp_cause | output | CAUSE_W | Cause of the error, 0 when OK |

## Verification
The bench builds the block with DEPTH=4, AX_W=16 and CAUSE_W=3. A four-entry record fills within a few cycles of random traffic, so back-pressure from a full record, replays of a full record and pointer wrap-around all occur many times. Both replay scopes and both reporting settings are exercised by switching the mode pins between phases. The narrow word still lets every replayed entry be compared against the order in which it was first sent.

// File: rtl/axr_pkg.sv
package axr_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HOLD   = 2'd1,
    ST_REPLAY = 2'd2
  } axr_state_t;

  typedef enum logic [1:0] {
    CMD_CONT   = 2'b00,
    CMD_ABORT  = 2'b01,
    CMD_REPLAY = 2'b10,
    CMD_RSVD   = 2'b11
  } axr_cmd_t;
endpackage

// File: rtl/axr_store.sv
module axr_store #(
  parameter int DEPTH = 8,
  parameter int W     = 48,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/axr_seq.sv
module axr_seq
  import axr_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          serial_mode,
  input  logic          in_valid,
  input  logic          out_ready,
  input  logic          done_valid,
  input  logic          done_err,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_sel,
  output logic          in_ready,
  output logic          out_valid,
  output logic          cmd_ready,
  output logic          replaying,
  output logic          push,
  output logic [IW-1:0] wr_idx,
  output logic [IW-1:0] rd_idx,
  output logic [IW:0]   occ,
  output logic          retire_ok,
  output logic          err_take
);
  localparam logic [IW:0] DEP_P = (IW+1)'(DEPTH);

  axr_state_t  st;
  logic [IW:0] wr_p, hd_p, rp, re;
  logic        full, empty, done_act, adv, take_cmd;

  assign occ      = wr_p - hd_p;
  assign full     = (occ == DEP_P);
  assign empty    = (occ == '0);
  assign in_ready = (st == ST_RUN) && out_ready && !full;
  assign out_valid = ((st == ST_RUN) && in_valid && !full) || (st == ST_REPLAY);
  assign cmd_ready = (st == ST_HOLD);
  assign replaying = (st == ST_REPLAY);
  assign push     = (st == ST_RUN) && in_valid && in_ready;
  assign done_act = done_valid && !empty && (st != ST_HOLD);
  assign retire_ok = done_act && !done_err;
  assign err_take = done_act && done_err;
  assign adv      = (st == ST_REPLAY) && out_ready;
  assign take_cmd = (st == ST_HOLD) && cmd_valid;
  assign wr_idx   = wr_p[IW-1:0];
  assign rd_idx   = rp[IW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_RUN;
      wr_p <= '0;
      hd_p <= '0;
      rp   <= '0;
      re   <= '0;
    end else begin
      if (push) wr_p <= wr_p + 1'b1;
      if (retire_ok) hd_p <= hd_p + 1'b1;
      if (adv) rp <= rp + 1'b1;

      if (err_take) begin
        st <= ST_HOLD;
      end else if (adv && ((rp + 1'b1) == re)) begin
        st <= ST_RUN;
      end

      if (take_cmd) begin
        case (cmd_sel)
          CMD_ABORT: begin
            hd_p <= wr_p;
            st   <= ST_RUN;
          end
          CMD_REPLAY: begin
            rp <= hd_p;
            re <= serial_mode ? (hd_p + 1'b1) : wr_p;
            st <= ST_REPLAY;
          end
          default: begin
            hd_p <= hd_p + 1'b1;
            st   <= ST_RUN;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/axr_report.sv
module axr_report #(
  parameter int CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               report_errors,
  input  logic               retire_ok,
  input  logic               err_take,
  input  logic [CAUSE_W-1:0] done_cause,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [CAUSE_W-1:0] rsp_cause
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_cause <= '0;
    end else begin
      rsp_valid <= retire_ok || (err_take && report_errors);
      rsp_err   <= err_take;
      rsp_cause <= err_take ? done_cause : '0;
    end
  end
endmodule

// File: rtl/ax_replay_ctl.sv
module ax_replay_ctl #(
  parameter int DEPTH   = 8,
  parameter int AX_W    = 48,
  parameter int CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               serial_mode,
  input  logic               report_errors,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [AX_W-1:0]    in_ax,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [AX_W-1:0]    out_ax,
  input  logic               done_valid,
  input  logic               done_err,
  input  logic [CAUSE_W-1:0] done_cause,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_sel,
  output logic               cmd_ready,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [CAUSE_W-1:0] rsp_cause
);
  localparam int IW = $clog2(DEPTH);

  logic          replaying, push, retire_ok, err_take;
  logic [IW-1:0] wr_idx, rd_idx;
  logic [IW:0]   occ;
  logic [AX_W-1:0] rec_word;

  axr_seq #(.DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .serial_mode(serial_mode),
    .in_valid(in_valid), .out_ready(out_ready),
    .done_valid(done_valid), .done_err(done_err),
    .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
    .in_ready(in_ready), .out_valid(out_valid), .cmd_ready(cmd_ready),
    .replaying(replaying), .push(push), .wr_idx(wr_idx), .rd_idx(rd_idx),
    .occ(occ), .retire_ok(retire_ok), .err_take(err_take)
  );

  axr_store #(.DEPTH(DEPTH), .W(AX_W)) u_store (
    .clk(clk), .we(push), .waddr(wr_idx), .wdata(in_ax),
    .raddr(rd_idx), .rdata(rec_word)
  );

  axr_report #(.CAUSE_W(CAUSE_W)) u_rep (
    .clk(clk), .rst_n(rst_n), .report_errors(report_errors),
    .retire_ok(retire_ok), .err_take(err_take), .done_cause(done_cause),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_cause(rsp_cause)
  );

  assign out_ax = replaying ? rec_word : in_ax;
endmodule

// File: rtl/axr_checker.sv
module axr_checker #(
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        done_valid,
  input logic        done_err,
  input logic        cmd_valid,
  input logic [1:0]  cmd_sel,
  input logic        cmd_ready,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic [IW:0] occ
);
  a_r5_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!out_valid && !in_ready));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (occ < (IW+1)'(DEPTH)));

  a_r4_ok_reply: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_err && occ != '0 && !cmd_ready) |=> (rsp_valid && !rsp_err));

  a_r8_abort_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && cmd_valid && cmd_sel == 2'b01) |=> (occ == '0));

  a_r7_continue_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && cmd_valid && cmd_sel[1] == cmd_sel[0]) |=> (occ == $past(occ) - 1'b1));

  a_r10_replay_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && cmd_valid && cmd_sel == 2'b10) |=> (out_valid && occ == $past(occ)));

  a_r12_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && occ == '0) |=> !rsp_valid);
endmodule

bind ax_replay_ctl axr_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .done_valid(done_valid), .done_err(done_err),
  .cmd_valid(cmd_valid), .cmd_sel(cmd_sel), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .occ(occ)
);

// File: tb/ax_replay_ctl_test.sv
`timescale 1ns/100ps
module ax_replay_ctl_test;
  localparam int D = 4;
  localparam int W = 16;
  localparam int C = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic serial_mode = 1'b0, report_errors = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b0, done_valid = 1'b0, done_err = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_sel = 2'b00;
  logic [W-1:0] in_ax = '0;
  logic [C-1:0] done_cause = '0;
  logic in_ready, out_valid, cmd_ready, rsp_valid, rsp_err;
  logic [W-1:0] out_ax;
  logic [C-1:0] rsp_cause;

  always #2.5 clk = ~clk;

  ax_replay_ctl #(.DEPTH(D), .AX_W(W), .CAUSE_W(C)) uut (
    .clk(clk), .rst_n(rst_n), .serial_mode(serial_mode), .report_errors(report_errors),
    .in_valid(in_valid), .in_ready(in_ready), .in_ax(in_ax),
    .out_valid(out_valid), .out_ready(out_ready), .out_ax(out_ax),
    .done_valid(done_valid), .done_err(done_err), .done_cause(done_cause),
    .cmd_valid(cmd_valid), .cmd_sel(cmd_sel), .cmd_ready(cmd_ready),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_cause(rsp_cause)
  );

  int vectors = 0, miscompares = 0;
  bit finished = 1'b0;

  logic [W-1:0] q[$];
  int mst = 0;            // 0 normal, 1 waiting for command, 2 replaying
  int ri = 0, re = 0;
  bit rep_err = 1'b0;
  bit e_rv = 1'b0, e_re = 1'b0;
  logic [C-1:0] e_rc = '0;
  string rtag = "R1";
  string force_tag = "";

  task automatic chk(input string tag, input string what, input longint got, input longint exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
    end
  endtask

  function automatic string state_tag();
    if (!rst_n) return "R1";
    if (mst == 1) return "R5";
    if (mst == 2) return serial_mode ? "R9" : "R10";
    if (q.size() == D) return "R3";
    return "R2";
  endfunction

  // one cycle: inputs already set after a falling edge
  task automatic tick();
    bit full, x_ov, x_ir, x_cr, dact, pop, adv_now;
    logic [W-1:0] x_ax;
    string tag;
    #1;
    tag = (force_tag != "") ? force_tag : state_tag();
    force_tag = "";
    full = (q.size() == D);
    x_ax = in_ax;
    case (mst)
      1: begin x_ov = 0; x_ir = 0; x_cr = 1; end
      2: begin x_ov = 1; x_ir = 0; x_cr = 0; x_ax = q[ri]; end
      default: begin x_ov = in_valid && !full; x_ir = out_ready && !full; x_cr = 0; end
    endcase
    chk(tag, "out_valid", out_valid, x_ov);
    chk(tag, "in_ready", in_ready, x_ir);
    chk(tag, "cmd_ready", cmd_ready, x_cr);
    if (x_ov) chk(tag, "out_ax", out_ax, x_ax);
    chk(rtag, "rsp_valid", rsp_valid, e_rv);
    if (e_rv) begin
      chk(rtag, "rsp_err", rsp_err, e_re);
      chk(rtag, "rsp_cause", rsp_cause, e_rc);
    end
    // model of the next state
    e_rv = 0; e_re = 0; e_rc = '0; rtag = "R4"; pop = 0;
    if (rst_n) begin
      dact = done_valid && q.size() > 0 && mst != 1;
      if (done_valid && q.size() == 0) rtag = "R12";
      if (dact && !done_err) begin e_rv = 1; pop = 1; end
      if (dact && done_err) begin
        e_rv = report_errors; e_re = 1; e_rc = done_cause;
        rtag = report_errors ? "R5" : "R6";
      end
      if (mst == 0 && in_valid && x_ir) q.push_back(in_ax);
      adv_now = (mst == 2) && out_ready;
      if (dact && done_err) begin
        if (mst == 2) rep_err = 1;
        mst = 1;
      end else if (adv_now) begin
        if (ri + 1 == re) mst = 0;
        ri++;
      end
      if (pop) begin void'(q.pop_front()); ri--; re--; end
      if (x_cr && cmd_valid) begin
        case (cmd_sel)
          2'b01: begin q.delete(); mst = 0; force_tag = "R8"; end
          2'b10: begin
            ri = 0; re = serial_mode ? 1 : q.size(); mst = 2;
            force_tag = rep_err ? "R11" : (serial_mode ? "R9" : "R10");
          end
          default: begin void'(q.pop_front()); mst = 0; force_tag = "R7"; end
        endcase
        rep_err = 0;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    in_valid = 0; done_valid = 0; done_err = 0; cmd_valid = 0; out_ready = 1;
  endtask

  function automatic bit done_ok_now();
    return q.size() > 0 && (mst == 0 || (mst == 2 && ri > 0));
  endfunction

  task automatic rand_phase(input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = ($urandom % 3) != 0;
      in_ax = W'($urandom);
      out_ready = ($urandom % 4) != 0;
      done_valid = 0; done_err = 0; cmd_valid = 0;
      if (done_ok_now() && ($urandom % 3) == 0) begin
        done_valid = 1;
        done_err = ($urandom % 5) == 0;
        done_cause = C'($urandom);
      end
      if (mst == 1 && ($urandom % 3) == 0) begin
        cmd_valid = 1;
        cmd_sel = 2'($urandom);
      end
      tick();
    end
  endtask

  task automatic push_n(input int n);
    for (int i = 0; i < n; i++) begin
      idle_inputs(); in_valid = 1; in_ax = W'(16'h100 + i); tick();
    end
  endtask

  task automatic drain();
    while (mst != 0 || q.size() > 0) begin
      idle_inputs();
      if (mst == 1) begin cmd_valid = 1; cmd_sel = 2'b01; end
      else if (done_ok_now()) done_valid = 1;
      tick();
    end
    idle_inputs(); tick();
  endtask

  initial begin
    #200000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    idle_inputs();
    tick(); tick();                     // R1 reset state
    rst_n = 1;
    idle_inputs(); tick();

    push_n(D + 2);                      // R2 then R3 when full
    drain();

    // R12: completion with an empty record
    idle_inputs(); done_valid = 1; tick();
    idle_inputs(); tick();

    // R11: error during non-serial replay, then replay again
    serial_mode = 0;
    push_n(3);
    idle_inputs(); done_valid = 1; done_err = 1; done_cause = 3'd5; tick();
    idle_inputs(); cmd_valid = 1; cmd_sel = 2'b10; tick();
    idle_inputs(); tick();              // oldest entry re-sent
    idle_inputs(); done_valid = 1; done_err = 1; done_cause = 3'd2; tick();
    idle_inputs(); cmd_valid = 1; cmd_sel = 2'b10; tick();
    for (int i = 0; i < 4; i++) begin idle_inputs(); tick(); end
    drain();

    // R7 reserved code, R9 serial replay
    serial_mode = 1;
    push_n(2);
    idle_inputs(); done_valid = 1; done_err = 1; done_cause = 3'd1; tick();
    idle_inputs(); cmd_valid = 1; cmd_sel = 2'b11; tick();
    idle_inputs(); done_valid = 1; done_err = 1; done_cause = 3'd6; tick();
    idle_inputs(); cmd_valid = 1; cmd_sel = 2'b10; out_ready = 0; tick();
    idle_inputs(); out_ready = 0; tick();
    idle_inputs(); tick(); tick();
    drain();

    serial_mode = 0; rand_phase(3000);
    drain();
    serial_mode = 1; rand_phase(3000);
    drain();
    report_errors = 0;                  // R6
    serial_mode = 0; rand_phase(2000);
    drain();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule